// File: doc/BRIEF.md
# Microprogrammed Memory Cycle Sequencer

This block runs one external memory access by stepping through a table of 32-bit control words. Two programmable machines each own a 64-word writable table. Every one of the eight banks carries a 2-bit machine-select code. A request names a bank and a start index. If the bank is routed to one of the programmable machines, the sequencer executes words one per clock from that index. Each word sets the level of that bank's chip-select and of the transfer-acknowledge output for one cycle. It can also mark the end of the program, and it can arm a per-bank recovery timer.

The recovery timer makes later requests to the same bank wait, for example to cover precharge. Requests to other banks are not held up. Banks routed to the fixed-timing machine, or to the unused code, are left alone by this block. Tables are loaded through a simple write port, and the bank configuration is supplied as flat vectors.

Word bit numbering below counts bit 0 as the most significant bit. So word bit n is data bit 31-n.

Top module: `mem_seq_engine`

## Requirements
- R1: The bank's select code picks the table. Code 2'b10 runs machine A's table (written with tbl_mach=0). Code 2'b11 runs machine B's table (tbl_mach=1).
- R2: A request to a bank whose code is 2'b00 or 2'b01 is ignored. All chip-selects stay high, and done and err stay low.
- R3: During a run only the accessed bank's chip-select may go low. All other chip-select lines stay high.
- R4: A request is sampled on a rising edge while the block is idle. Word k of the program sets the outputs for the cycle after edge 2+k counted from that sampling edge, plus any lockout wait. Chip-selects are active low. The selected line takes the value of word bit 0 (data bit 31).
- R5: transfer-acknowledge (active low) takes the value of word bit 29 (data bit 2) in the same cycle as that word's chip-select level.
- R6: Word bit 31 (data bit 0) marks the last word. done is high for exactly the cycle showing the last word's outputs. In the next cycle all chip-selects and acknowledge return high.
- R7: Word bit 30 (data bit 1) loads the bank's timer from its 4-bit period only when word bit 29 is 0. When word bit 29 is 1, the timer bit has no effect.
- R8: While a bank's timer is nonzero, a new request to that bank waits, with chip-selects high. The timer counts down once per clock. A request sampled one cycle after done waits period-1 extra cycles. Other banks are not delayed.
- R9: Suppose index 63 runs without its last bit set. Then err is high in the cycle showing that word's outputs, done stays low, and the block returns to idle.
- R10: A request that arrives while a run is in progress is ignored.
- R11: After reset all chip-selects and acknowledge are high, and done and err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_bank | input | 3 | Bank to access |
| req_start | input | 6 | Start index in the table |
| tbl_we | input | 1 | Table write enable |
| tbl_mach | input | 1 | Table to write: 0 machine A, 1 machine B |
| tbl_addr | input | 6 | Table word index |
| tbl_data | input | 32 | Word to write |
| bank_msel | input | 16 | Select code per bank, bank b at bits 2b+1:2b |
| bank_period | input | 32 | Recovery period per bank, bank b at bits 4b+3:4b |
| cs_n | output | 8 | Active-low chip-selects, one per bank |
| ack_n | output | 1 | Active-low transfer acknowledge |
| done | output | 1 | One-cycle pulse with the last word |
| err | output | 1 | One-cycle pulse on index overflow |

## Verification
The hardest case to reach from the ports is the lockout. A program must first load a bank's timer with its final word, and then a second request to the same bank must arrive while the timer is still counting. The stimulus does this by issuing a back-to-back request to that bank. It then checks every cycle that the chip-selects stay high for exactly period-1 cycles before the program replays. Right after that, a request to a neighbouring bank checks that other banks are not delayed. A final-word variant with acknowledge high shows the timer bit being ignored.

// File: rtl/mem_seq_engine.sv
module mem_seq_engine #(
  parameter int NB = 8,
  parameter int DEPTH = 64,
  parameter int TW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [$clog2(NB)-1:0]   req_bank,
  input  logic [$clog2(DEPTH)-1:0] req_start,
  input  logic                    tbl_we,
  input  logic                    tbl_mach,
  input  logic [$clog2(DEPTH)-1:0] tbl_addr,
  input  logic [31:0]             tbl_data,
  input  logic [2*NB-1:0]         bank_msel,
  input  logic [TW*NB-1:0]        bank_period,
  output logic [NB-1:0]           cs_n,
  output logic                    ack_n,
  output logic                    done,
  output logic                    err
);
  localparam int BW = $clog2(NB);
  localparam int IW = $clog2(DEPTH);
  localparam int CS_BIT = 31;
  localparam int ACK_BIT = 2;
  localparam int TMR_BIT = 1;
  localparam int LAST_BIT = 0;
  localparam logic [IW-1:0] IDX_MAX = IW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;

  state_t          state;
  logic [BW-1:0]   cur_bank;
  logic            cur_mach;
  logic [IW-1:0]   idx;
  logic [31:0]     table_q [2*DEPTH];
  logic [TW-1:0]   tmr [NB];

  wire [31:0] word = table_q[{cur_mach, idx}];
  wire        arm  = (state == S_RUN) && !word[ACK_BIT] && word[TMR_BIT];
  wire [1:0]  req_sel = bank_msel[2*req_bank +: 2];
  logic unused_word_bits;
  assign unused_word_bits = ^word[30:3];

  always_ff @(posedge clk)
    if (tbl_we) table_q[{tbl_mach, tbl_addr}] <= tbl_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) tmr[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++)
        if (arm && cur_bank == BW'(b)) tmr[b] <= bank_period[TW*b +: TW];
        else if (tmr[b] != '0)         tmr[b] <= tmr[b] - {{(TW-1){1'b0}}, 1'b1};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cur_bank <= '0;
      cur_mach <= 1'b0;
      idx <= '0;
      cs_n <= '1;
      ack_n <= 1'b1;
      done <= 1'b0;
      err <= 1'b0;
    end else begin
      cs_n <= '1;
      ack_n <= 1'b1;
      done <= 1'b0;
      err <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid && req_sel[1]) begin
            cur_bank <= req_bank;
            cur_mach <= req_sel[0];
            idx <= req_start;
            state <= (tmr[req_bank] != '0) ? S_WAIT : S_RUN;
          end
        S_WAIT:
          if (tmr[cur_bank] == '0) state <= S_RUN;
        S_RUN: begin
          cs_n[cur_bank] <= word[CS_BIT];
          ack_n <= word[ACK_BIT];
          idx <= idx + {{(IW-1){1'b0}}, 1'b1};
          if (word[LAST_BIT]) begin
            done <= 1'b1;
            state <= S_IDLE;
          end else if (idx == IDX_MAX) begin
            err <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end

  assert_single_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_done_not_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);
  assert_ignore_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req_valid && !req_sel[1]) |=> (state == S_IDLE));
  assert_lockout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && tmr[cur_bank] != '0) |=> (state == S_WAIT));
  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_RUN) |=> (cs_n == '1 && ack_n && !done && !err));
endmodule

// File: tb/mem_seq_engine_test.sv
module mem_seq_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_bank = '0;
  logic [5:0] req_start = '0;
  logic tbl_we = 1'b0, tbl_mach = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic [31:0] tbl_data = '0;
  logic [15:0] bank_msel;
  logic [31:0] bank_period;
  logic [7:0] cs_n;
  logic ack_n, done, err;

  logic [31:0] model [2][64];
  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_seq_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_start(req_start), .tbl_we(tbl_we), .tbl_mach(tbl_mach),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .bank_msel(bank_msel),
    .bank_period(bank_period), .cs_n(cs_n), .ack_n(ack_n), .done(done), .err(err));

  function automatic logic [31:0] mkw(bit cs, bit ack, bit tmr, bit last);
    return {cs, cs, cs, cs, 24'h0, 1'b0, ack, tmr, last};
  endfunction

  task automatic chk(string rq, logic [7:0] cs_e, bit ack_e, bit done_e, bit err_e);
    vectors++;
    if (cs_n !== cs_e || ack_n !== ack_e || done !== done_e || err !== err_e) begin
      fails++;
      $display("FAIL %s t=%0t cs_n=%b ack_n=%b done=%b err=%b expected cs_n=%b ack_n=%b done=%b err=%b",
               rq, $time, cs_n, ack_n, done, err, cs_e, ack_e, done_e, err_e);
    end
  endtask

  task automatic wr(bit m, int a, logic [31:0] d);
    model[m][a] = d;
    tbl_we = 1'b1; tbl_mach = m; tbl_addr = 6'(a); tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_case(string rq, int bank, int start, int waitc, bit poke);
    bit m = bank_msel[2*bank];
    int idx = start;
    logic [31:0] w;
    logic [7:0] ecs;
    req_valid = 1'b1; req_bank = 3'(bank); req_start = 6'(start);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= waitc; i++) begin
      chk({rq, " R8 wait/idle"}, 8'hFF, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
    end
    for (int k = 0; k < 64; k++) begin
      w = model[m][idx];
      ecs = 8'hFF;
      ecs[bank] = w[31];
      chk({rq, " R4 R5 R6 word"}, ecs, w[2], w[0], (idx == 63) && !w[0]);
      req_valid = 1'b0;
      if (poke && k == 1) begin
        req_valid = 1'b1; req_bank = 3'd2; req_start = 6'd0;
      end
      if (w[0] || idx == 63) break;
      idx++;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " R6 return idle"}, 8'hFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R11 reset", 8'hFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_select;
    run_case("R1 machA bank2", 2, 0, 0, 1'b0);
    run_case("R1 R3 machB bank5", 5, 0, 0, 1'b0);
  endtask

  task automatic t_ignored(int bank);
    req_valid = 1'b1; req_bank = 3'(bank); req_start = 6'd0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R2 ignored bank", 8'hFF, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic t_lockout;
    run_case("R7 arm bank3", 3, 20, 0, 1'b0);
    run_case("R8 locked bank3", 3, 20, 4, 1'b0);
    run_case("R8 other bank4", 4, 20, 0, 1'b0);
  endtask

  task automatic t_tmr_ignored;
    run_case("R7 ack high bank6", 6, 30, 0, 1'b0);
    run_case("R7 no lock bank6", 6, 30, 0, 1'b0);
  endtask

  task automatic t_overflow;
    run_case("R9 overflow bank7", 7, 60, 0, 1'b0);
  endtask

  task automatic t_busy;
    run_case("R10 busy req", 4, 40, 0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk("R10 no second run", 8'hFF, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bank_msel = {2'b10, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b01, 2'b00};
    bank_period = '0;
    bank_period[4*3 +: 4] = 4'd5;
    bank_period[4*4 +: 4] = 4'd5;
    bank_period[4*6 +: 4] = 4'd7;
    for (int a = 0; a < 64; a++) begin
      model[0][a] = mkw(1, 1, 0, 1);
      model[1][a] = mkw(1, 1, 0, 1);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    wr(0, 0, mkw(1, 1, 0, 0)); wr(0, 1, mkw(0, 1, 0, 0));
    wr(0, 2, mkw(0, 0, 0, 0)); wr(0, 3, mkw(1, 1, 0, 1));
    wr(1, 0, mkw(0, 0, 0, 0)); wr(1, 1, mkw(0, 1, 0, 1));
    wr(0, 20, mkw(0, 1, 0, 0)); wr(0, 21, mkw(0, 0, 1, 1));
    wr(0, 30, mkw(0, 1, 0, 0)); wr(0, 31, mkw(1, 1, 1, 1));
    wr(0, 40, mkw(0, 1, 0, 0)); wr(0, 41, mkw(0, 0, 0, 0));
    wr(0, 42, mkw(0, 0, 0, 0)); wr(0, 43, mkw(1, 1, 0, 1));
    wr(0, 60, mkw(0, 1, 0, 0)); wr(0, 61, mkw(1, 0, 0, 0));
    wr(0, 62, mkw(0, 0, 0, 0)); wr(0, 63, mkw(0, 1, 0, 0));
    @(negedge clk);
    chk("R11 idle after load", 8'hFF, 1'b1, 1'b0, 1'b0);
    t_select();
    t_ignored(0);
    t_ignored(1);
    t_lockout();
    t_tmr_ignored();
    t_overflow();
    t_busy();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule